// File: doc/BRIEF.md
# Serial-by-parallel two's-complement multiplier

This block multiplies a signed parallel operand of `PAR_W` bits by a signed operand of `SER_W` bits. The parallel operand is captured on a start pulse and then held. The serial operand enters one bit per clock, least significant bit first. The block is a chain of identical one-bit cells. Each cell holds a sum flip-flop and a carry flip-flop and does one full-adder step per clock. Each cell is wired only to its neighbour. The current serial bit is the only signal that goes to every cell.

The product has `PAR_W+SER_W` bits and leaves the least significant cell one bit per clock, least significant bit first. The caller drives only the `SER_W` real operand bits. The block repeats the captured sign bit for the remaining `PAR_W` steps, so a product takes `PAR_W+SER_W` clocks. A one-cycle done flag marks the last product bit. An optional shift register can also gather the stream into a product word.

Top module: `smul_serpar`

## Requirements
- R1: With start high in cycle 0 and serial bit t of the operand on `ser_in` in cycle t, `ser_out` carries bit t of the two's-complement product (`PAR_W+SER_W` bits) after clock edge t, for t = 0 .. `PAR_W+SER_W-1`.
- R2: Only cycles 0 .. `SER_W-1` sample `ser_in`. In the remaining `PAR_W` steps the block reuses serial bit `SER_W-1` as the sign, so `ser_in` has no effect on the product in those cycles.
- R3: `mcand` is sampled only in the start cycle. Changing it during the product has no effect on the result.
- R4: `done` is high for exactly one cycle, after edge `PAR_W+SER_W-1`, the same cycle in which the final product bit is on `ser_out`.
- R5: A start pulse clears every sum and carry flip-flop and begins a new product. This holds when it comes in the middle of a product (abort) and when it comes in the done cycle with no idle cycle between products.
- R6: A synchronous active-high reset drives `ser_out`, `done` and `prod_word` to 0.
- R7: When `CAPTURE` is 1, `prod_word` holds the full product, with bit t equal to serial bit t, from the done cycle until the next start.
- R8: While no product is running, `ser_out` and `prod_word` hold their values whatever `ser_in` and `mcand` do.
- R9: The product is correct at the extremes: both operands at their most negative value, one most negative and one most positive, and the operands -1 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a product; carries serial bit 0 in the same cycle |
| mcand | input | PAR_W | Signed parallel operand, sampled when start is high |
| ser_in | input | 1 | Serial operand bit, least significant first |
| ser_out | output | 1 | Product bit stream, least significant first |
| done | output | 1 | One-cycle flag with the final product bit |
| prod_word | output | PAR_W+SER_W | Gathered product (zero when CAPTURE is 0) |

## Verification
Small positive operands check the plain shift-add path. Runs that mix signs, and runs with -1 or the most negative values, check the inverted partial product in the sign cell and the injected correction constant. A single wrong weight there changes the upper product bits. In some runs, random bits are driven on the serial input during the sign-extension steps, and in others the parallel operand changes after start. These runs separate a block that holds its captured values from one that keeps sampling its inputs. Aborted products and back-to-back products check that the start cycle clears the carry state left from the previous product.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // One-bit full adder, split into its sum and carry outputs.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/smul_cell.sv
module smul_cell
  import smul_pkg::*;
#(
  parameter bit SIGN_CELL = 1'b0   // cell at the sign weight of the parallel operand
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,   // one multiply step this cycle
  input  logic first,     // step 0: ignore stored state
  input  logic a_bit,     // this cell's bit of the parallel operand
  input  logic x_bit,     // broadcast serial bit
  input  logic sum_in,    // registered sum of the next more significant cell
  output logic sum_d,     // sum value being written this step
  output logic sum_q
);

  logic carry_q;
  logic pp, s_in, c_in, carry_d;

  // The sign cell uses an inverted partial product. On the first step it also
  // injects a one at its weight. Over the whole run this turns the unsigned sum
  // into the two's-complement product modulo 2^(PAR_W+SER_W).
  always_comb begin
    pp      = (a_bit & x_bit) ^ SIGN_CELL;
    s_in    = first ? SIGN_CELL : sum_in;
    c_in    = first ? 1'b0 : carry_q;
    sum_d   = fa_sum(s_in, pp, c_in);
    carry_d = fa_carry(s_in, pp, c_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (step_en) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  // R8: an idle cell keeps its sum and carry
  assert_cell_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(sum_q) && $stable(carry_q)));

endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int PAR_W = 8,
  parameter int SER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAR_W-1:0] mcand,
  input  logic             ser_in,
  output logic             step_en,
  output logic             first,
  output logic [PAR_W-1:0] a_eff,
  output logic             x_eff,
  output logic             done
);

  localparam int TOT = PAR_W + SER_W;
  localparam int CW  = $clog2(TOT + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    step_idx;
  logic [PAR_W-1:0] a_q;
  logic             sign_q;
  logic             last;

  always_comb begin
    step_en  = start | busy;
    first    = start;
    step_idx = start ? '0 : cnt;
    a_eff    = start ? mcand : a_q;
    // the block extends the serial operand with its own copy of the sign bit
    x_eff    = (step_idx < CW'(SER_W)) ? ser_in : sign_q;
    last     = step_en && (step_idx == CW'(TOT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      a_q    <= '0;
      sign_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (start) a_q <= mcand;
      if (step_en) begin
        if (step_idx == CW'(SER_W - 1)) sign_q <= ser_in;
        busy <= ~last;
        cnt  <= step_idx + 1'b1;
      end
    end
  end

  // R4: done lasts one cycle
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: done only follows a running product
  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R5: start always leaves the block running
  assert_start_runs_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R1: the step counter stays inside one product
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(TOT)));

  // R2: the sign is not resampled during the extension steps
  assert_sign_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && (cnt >= CW'(SER_W))) |=> $stable(sign_q));

  // R3: the held operand changes only on start
  assert_mcand_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(a_q));

endmodule

// File: rtl/smul_capture.sv
module smul_capture #(
  parameter int TOT = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic           bit_in,
  output logic [TOT-1:0] word
);

  // Product bits enter at the top and move down, so after TOT steps bit 0
  // sits in word[0].
  always_ff @(posedge clk) begin
    if (rst)          word <= '0;
    else if (step_en) word <= {bit_in, word[TOT-1:1]};
  end

  // R8: the gathered word holds while idle
  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(word));

endmodule

// File: rtl/smul_serpar.sv
module smul_serpar #(
  parameter int PAR_W   = 8,
  parameter int SER_W   = 8,
  parameter bit CAPTURE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [PAR_W-1:0]       mcand,
  input  logic                   ser_in,
  output logic                   ser_out,
  output logic                   done,
  output logic [PAR_W+SER_W-1:0] prod_word
);

  localparam int TOT = PAR_W + SER_W;

  logic             step_en, first, x_eff;
  logic [PAR_W-1:0] a_eff;
  logic [PAR_W-1:0] sum_q;
  logic [PAR_W-1:0] sum_d;

  smul_seq #(.PAR_W(PAR_W), .SER_W(SER_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .ser_in(ser_in),
    .step_en(step_en), .first(first), .a_eff(a_eff), .x_eff(x_eff),
    .done(done)
  );

  for (genvar i = 0; i < PAR_W; i++) begin : g_cell
    if (i == PAR_W - 1) begin : g_sign
      smul_cell #(.SIGN_CELL(1'b1)) cell_i (
        .clk(clk), .rst(rst), .step_en(step_en), .first(first),
        .a_bit(a_eff[i]), .x_bit(x_eff), .sum_in(1'b0),
        .sum_d(sum_d[i]), .sum_q(sum_q[i])
      );
    end else begin : g_mag
      smul_cell #(.SIGN_CELL(1'b0)) cell_i (
        .clk(clk), .rst(rst), .step_en(step_en), .first(first),
        .a_bit(a_eff[i]), .x_bit(x_eff), .sum_in(sum_q[i+1]),
        .sum_d(sum_d[i]), .sum_q(sum_q[i])
      );
    end
  end

  assign ser_out = sum_q[0];

  if (CAPTURE) begin : g_cap
    smul_capture #(.TOT(TOT)) cap_i (
      .clk(clk), .rst(rst), .step_en(step_en), .bit_in(sum_d[0]),
      .word(prod_word)
    );
  end else begin : g_nocap
    assign prod_word = '0;
  end

  // R6: outputs are quiet straight after reset
  assert_reset_quiet_R6: assert property (@(posedge clk)
    $past(rst) |-> (!done && !ser_out));

endmodule

// File: tb/smul_serpar_tb.sv
module smul_serpar_tb_top;

  localparam int M = 8;
  localparam int N = 8;
  localparam int T = M + N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [M-1:0] mcand = '0;
  logic         ser_in = 1'b0;
  logic         ser_out, done;
  logic [T-1:0] prod_word;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  smul_serpar #(.PAR_W(M), .SER_W(N), .CAPTURE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .ser_in(ser_in),
    .ser_out(ser_out), .done(done), .prod_word(prod_word)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [T-1:0] want(input logic [M-1:0] a, input logic [N-1:0] b);
    longint av, bv, pv;
    av = longint'($signed(a));
    bv = longint'($signed(b));
    pv = av * bv;
    return pv[T-1:0];
  endfunction

  // Called at a falling edge. Runs one complete product and ends at a falling edge.
  task automatic run_product(input logic [M-1:0] a, input logic [N-1:0] b,
                             input bit junk_ext, input bit wiggle_a, input string tag);
    logic [T-1:0] got = '0;
    logic [T-1:0] exp;
    int done_err = 0;
    exp    = want(a, b);
    mcand  = a;
    ser_in = b[0];
    start  = 1'b1;
    for (int t = 0; t < T; t++) begin
      @(negedge clk);
      got[t] = ser_out;
      if (done !== (t == T - 1)) done_err++;
      start = 1'b0;
      if (t + 1 < N) ser_in = b[t+1];
      else           ser_in = junk_ext ? 1'($urandom) : b[N-1];
      if (wiggle_a) mcand = M'($urandom);
    end
    check({tag, " serial product"}, 64'(got), 64'(exp));
    check("R4 done timing", 64'(done_err), 64'd0);
    check("R7 captured word", 64'(prod_word), 64'(exp));
  endtask

  // Starts a product and abandons it after a few steps.
  task automatic partial_product(input logic [M-1:0] a, input logic [N-1:0] b, input int steps);
    mcand  = a;
    ser_in = b[0];
    start  = 1'b1;
    for (int t = 0; t < steps; t++) begin
      @(negedge clk);
      start  = 1'b0;
      ser_in = b[(t + 1) % N];
    end
  endtask

  task automatic test_reset();
    check("R6 ser_out after reset", 64'(ser_out), 64'd0);
    check("R6 done after reset", 64'(done), 64'd0);
    check("R6 prod_word after reset", 64'(prod_word), 64'd0);
  endtask

  task automatic test_basic();
    run_product(8'd3, 8'd5, 1'b0, 1'b0, "R1 3*5");
    run_product(8'd100, 8'd77, 1'b0, 1'b0, "R1 100*77");
    run_product(8'hF9, 8'd11, 1'b0, 1'b0, "R1 -7*11");
    run_product(8'd13, 8'hE0, 1'b0, 1'b0, "R1 13*-32");
  endtask

  task automatic test_extremes();
    run_product(8'h80, 8'h80, 1'b0, 1'b0, "R9 min*min");
    run_product(8'h80, 8'h7F, 1'b0, 1'b0, "R9 min*max");
    run_product(8'h7F, 8'h80, 1'b0, 1'b0, "R9 max*min");
    run_product(8'hFF, 8'hFF, 1'b0, 1'b0, "R9 -1*-1");
    run_product(8'h00, 8'h80, 1'b0, 1'b0, "R9 0*min");
    run_product(8'hFF, 8'h00, 1'b0, 1'b0, "R9 -1*0");
  endtask

  task automatic test_ignored_inputs();
    run_product(8'hA5, 8'h96, 1'b1, 1'b0, "R2 junk during extension");
    run_product(8'h3C, 8'h81, 1'b1, 1'b0, "R2 junk during extension");
    run_product(8'h81, 8'h5A, 1'b0, 1'b1, "R3 operand wiggle");
  endtask

  task automatic test_restart();
    partial_product(8'h7F, 8'h7F, 5);
    run_product(8'h91, 8'h23, 1'b0, 1'b0, "R5 abort then restart");
    // back-to-back: start sampled in the done cycle
    run_product(8'hC4, 8'hEE, 1'b0, 1'b0, "R5 back-to-back");
  endtask

  task automatic test_idle();
    logic         so;
    logic [T-1:0] pw;
    int           moved = 0;
    so = ser_out;
    pw = prod_word;
    for (int k = 0; k < 6; k++) begin
      ser_in = ~ser_in;
      mcand  = M'($urandom);
      @(negedge clk);
      if (ser_out !== so || prod_word !== pw || done !== 1'b0) moved++;
    end
    check("R8 idle hold", 64'(moved), 64'd0);
  endtask

  task automatic test_random();
    for (int k = 0; k < 20; k++) begin
      run_product(M'($urandom), N'($urandom), 1'b1, 1'b1, "R1 random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_idle();
    test_extremes();
    test_ignored_inputs();
    test_restart();
    test_idle();
    test_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule